// File: doc/BRIEF.md
# Protected Return Stack Unit

This block keeps return addresses on a dedicated stack in memory. Ordinary code cannot reach that stack. The CPU has 24-bit addresses and a 16-bit data path. A call stores the 24-bit return address as two 16-bit words: the low word first, then a word that carries the top 8 address bits in its low byte. The upper byte of that second word is a frame-size field counted in 16-bit words. An enter operation records how much local space the routine reserved, and the unit computes the lowered data stack pointer for the core.

If a frame holds fewer than 255 words, the enter operation writes the count into the size field. If the frame is 255 words or more, the field takes the escape value 255. The unit then lifts the entry two words higher and stores the full 24-bit data stack pointer in the two words under it. A return reads the entry back and hands the return address to the fetch logic. It also rebuilds the caller's data stack pointer, adds the return's byte count to discard arguments, and drives the result to the core, so the routine needs no epilogue. The return stack changes only through calls, enter operations, returns and a supervisor write of the stack pointer.

Top module: `ret_stack_unit`

## Requirements
- R1: A call writes the low 16 bits of the return address at address RSP. It then writes the word {8'h00, address[23:16]} at RSP+2. After the second write, RSP increases by 4.
- R2: An enter with a word count n below 255 rewrites the word at RSP-2 to {n[7:0], address[23:16]}. RSP does not change. The unit drives the data stack pointer dsp_i - 2n.
- R3: An enter with n of 255 or more stores dsp_i[15:0] at RSP-4 and {8'h00, dsp_i[23:16]} at RSP-2. It then stores the return low word at RSP and {8'hFF, address[23:16]} at RSP+2, adds 4 to RSP, and drives dsp_i - 2n.
- R4: A return from an entry whose size field s is not 255 presents the 24-bit return address. It drives the data stack pointer dsp_i + 2s + imm and lowers RSP by 4.
- R5: A return from an entry whose size field is 255 drives the saved 24-bit pointer plus imm and lowers RSP by 8.
- R6: A return or enter issued while RSP equals the base register raises uf_fault_o. It makes no memory access, does not assert ret_valid_o or dsp_we_o, and leaves RSP unchanged.
- R7: An RSP write in supervisor mode loads both RSP and the base register. A write outside supervisor mode raises priv_fault_o one cycle later and leaves RSP unchanged.
- R8: The RSP read port shows RSP in supervisor mode and zero otherwise.
- R9: RSP changes only when an operation completes or on a supervisor write. Reset clears RSP and the base register, and the unit starts idle.
- R10: Results are registered and appear with a one-cycle done_o pulse, counted in cycles after the cycle in which the strobe is sampled. A call, a short enter and a normal return take 2 cycles. A return from an escape entry takes 4 cycles, and a long enter takes 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sup_i | input | 1 | Supervisor mode |
| call_i | input | 1 | Call strobe |
| call_addr_i | input | 24 | Return address to push |
| ret_i | input | 1 | Return strobe |
| ret_imm_i | input | 16 | Argument bytes to discard on return |
| enter_i | input | 1 | Enter strobe |
| enter_words_i | input | 16 | Local frame size in words |
| dsp_i | input | 24 | Current data stack pointer |
| rsp_wr_i | input | 1 | RSP write strobe |
| rsp_wdata_i | input | 24 | RSP write value |
| rsp_rd_o | output | 24 | RSP read port, zero outside supervisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished pulse |
| ret_valid_o | output | 1 | Return target valid pulse |
| ret_addr_o | output | 24 | Return target address |
| dsp_we_o | output | 1 | Data stack pointer update pulse |
| dsp_o | output | 24 | New data stack pointer |
| uf_fault_o | output | 1 | Return stack underflow fault |
| priv_fault_o | output | 1 | Privilege fault on RSP write |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 24 | Memory byte address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, same cycle |

## Verification
The bench crosses frame sizes on both sides of the escape threshold (0, 1, 254, 255 and larger) with several argument counts. If the threshold comparison were off by one, a 254-word frame would take the escape path or a 255-word frame would store the escape code as a plain size, and either mistake gives the wrong RSP step and a wrong restored pointer. The bench reads the stack words in memory directly, so swapped word order or a lost high byte shows up before the return runs. It also runs nested calls, where an escape entry must not corrupt the entry below it. Returns and enters on an empty stack and RSP writes from user mode must leave RSP where it was. A design that decremented before the underflow check, or ignored the mode, would move the pointer.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CALL_HI, S_RET_LO, S_RET_SH, S_RET_SL,
    S_ENT_WR, S_ENT_RL, S_ENT_W0, S_ENT_W1, S_ENT_W2, S_ENT_W3
  } rsu_st_e;
endpackage

// File: rtl/rsu_ptr.sv
module rsu_ptr #(
  parameter int AW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sup_i,
  input  logic          wr_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          upd_i,
  input  logic [AW-1:0] nxt_i,
  output logic [AW-1:0] rsp_o,
  output logic [AW-1:0] rd_o,
  output logic          empty_o,
  output logic          priv_fault_o
);
  logic [AW-1:0] rsp_q, base_q;
  logic          priv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q  <= '0;
      base_q <= '0;
      priv_q <= 1'b0;
    end else begin
      priv_q <= wr_i && !sup_i;
      if (upd_i) rsp_q <= nxt_i;
      else if (wr_i && sup_i) begin
        rsp_q  <= wdata_i;
        base_q <= wdata_i;
      end
    end
  end

  assign rsp_o        = rsp_q;
  assign rd_o         = sup_i ? rsp_q : '0;
  assign empty_o      = (rsp_q == base_q);
  assign priv_fault_o = priv_q;

  // R9
  rsp_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rsp_q) |-> $past(upd_i || (wr_i && sup_i)));
  // R7
  priv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sup_i && !upd_i) |=> ($stable(rsp_q) && priv_fault_o));
  // R6
  floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_q >= base_q);
endmodule

// File: rtl/rsu_seq.sv
module rsu_seq
  import rsu_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          call_i,
  input  logic [AW-1:0] call_addr_i,
  input  logic          ret_i,
  input  logic [DW-1:0] ret_imm_i,
  input  logic          enter_i,
  input  logic [DW-1:0] enter_words_i,
  input  logic [AW-1:0] dsp_i,
  input  logic [AW-1:0] rsp_i,
  input  logic          empty_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          ret_valid_o,
  output logic [AW-1:0] ret_addr_o,
  output logic          dsp_we_o,
  output logic [AW-1:0] dsp_o,
  output logic          uf_fault_o,
  output logic          upd_o,
  output logic [AW-1:0] nxt_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam int HIW = AW - DW;
  localparam int SZW = DW - HIW;
  localparam logic [SZW-1:0] ESC   = '1;
  localparam logic [DW-1:0]  ESC_W = DW'(ESC);
  localparam logic [AW-1:0]  O2 = AW'(2);
  localparam logic [AW-1:0]  O4 = AW'(4);
  localparam logic [AW-1:0]  O6 = AW'(6);
  localparam logic [AW-1:0]  O8 = AW'(8);

  rsu_st_e        st_q, st_d;
  logic [HIW-1:0] hi_q, sph_q;
  logic [DW-1:0]  lo_q, imm_q, wds_q;
  logic [SZW-1:0] sz_q;
  logic [AW-1:0]  dsl_q;
  logic           f_done, f_ret, f_dwe, f_uf;
  logic [AW-1:0]  f_addr, f_dsp;
  logic           done_q, rv_q, dwe_q, uf_q;
  logic [AW-1:0]  ra_q, dsp_q;

  always_comb begin
    st_d = st_q;
    mem_req_o = 1'b0; mem_we_o = 1'b0; mem_addr_o = rsp_i; mem_wdata_o = '0;
    upd_o = 1'b0; nxt_o = rsp_i;
    f_done = 1'b0; f_ret = 1'b0; f_dwe = 1'b0; f_uf = 1'b0;
    f_addr = {hi_q, lo_q}; f_dsp = '0;
    case (st_q)
      S_IDLE: begin
        if (call_i) begin
          mem_req_o = 1'b1; mem_we_o = 1'b1;
          mem_wdata_o = call_addr_i[DW-1:0];
          st_d = S_CALL_HI;
        end else if (ret_i || enter_i) begin
          if (empty_i) begin
            f_uf = 1'b1; f_done = 1'b1;
          end else begin
            mem_req_o = 1'b1; mem_addr_o = rsp_i - O2;
            if (ret_i) st_d = S_RET_LO;
            else st_d = (enter_words_i < ESC_W) ? S_ENT_WR : S_ENT_RL;
          end
        end
      end
      S_CALL_HI: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1; mem_addr_o = rsp_i + O2;
        mem_wdata_o = {{SZW{1'b0}}, hi_q};
        upd_o = 1'b1; nxt_o = rsp_i + O4; f_done = 1'b1; st_d = S_IDLE;
      end
      S_RET_LO: begin
        mem_req_o = 1'b1; mem_addr_o = rsp_i - O4;
        if (sz_q != ESC) begin
          upd_o = 1'b1; nxt_o = rsp_i - O4;
          f_done = 1'b1; f_ret = 1'b1; f_dwe = 1'b1;
          f_addr = {hi_q, mem_rdata_i};
          f_dsp = dsl_q + AW'({sz_q, 1'b0}) + AW'(imm_q);
          st_d = S_IDLE;
        end else st_d = S_RET_SH;
      end
      S_RET_SH: begin
        mem_req_o = 1'b1; mem_addr_o = rsp_i - O6; st_d = S_RET_SL;
      end
      S_RET_SL: begin
        mem_req_o = 1'b1; mem_addr_o = rsp_i - O8;
        upd_o = 1'b1; nxt_o = rsp_i - O8;
        f_done = 1'b1; f_ret = 1'b1; f_dwe = 1'b1;
        f_dsp = {sph_q, mem_rdata_i} + AW'(imm_q);
        st_d = S_IDLE;
      end
      S_ENT_WR: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1; mem_addr_o = rsp_i - O2;
        mem_wdata_o = {wds_q[SZW-1:0], hi_q};
        f_done = 1'b1; f_dwe = 1'b1; f_dsp = dsl_q - AW'({wds_q, 1'b0});
        st_d = S_IDLE;
      end
      S_ENT_RL: begin
        mem_req_o = 1'b1; mem_addr_o = rsp_i - O4; st_d = S_ENT_W0;
      end
      S_ENT_W0: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1; mem_addr_o = rsp_i - O4;
        mem_wdata_o = dsl_q[DW-1:0]; st_d = S_ENT_W1;
      end
      S_ENT_W1: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1; mem_addr_o = rsp_i - O2;
        mem_wdata_o = {{SZW{1'b0}}, dsl_q[AW-1:DW]}; st_d = S_ENT_W2;
      end
      S_ENT_W2: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1; mem_addr_o = rsp_i;
        mem_wdata_o = lo_q; st_d = S_ENT_W3;
      end
      S_ENT_W3: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1; mem_addr_o = rsp_i + O2;
        mem_wdata_o = {ESC, hi_q};
        upd_o = 1'b1; nxt_o = rsp_i + O4;
        f_done = 1'b1; f_dwe = 1'b1; f_dsp = dsl_q - AW'({wds_q, 1'b0});
        st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; hi_q <= '0; sph_q <= '0; lo_q <= '0; imm_q <= '0;
      wds_q <= '0; sz_q <= '0; dsl_q <= '0;
      done_q <= 1'b0; rv_q <= 1'b0; dwe_q <= 1'b0; uf_q <= 1'b0;
      ra_q <= '0; dsp_q <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= f_done; rv_q <= f_ret; dwe_q <= f_dwe; uf_q <= f_uf;
      if (f_ret) ra_q <= f_addr;
      if (f_dwe) dsp_q <= f_dsp;
      case (st_q)
        S_IDLE: begin
          if (call_i) begin
            lo_q <= call_addr_i[DW-1:0];
            hi_q <= call_addr_i[AW-1:DW];
          end else if ((ret_i || enter_i) && !empty_i) begin
            hi_q  <= mem_rdata_i[HIW-1:0];
            sz_q  <= mem_rdata_i[DW-1:HIW];
            dsl_q <= dsp_i;
            imm_q <= ret_imm_i;
            wds_q <= enter_words_i;
          end
        end
        S_RET_LO, S_ENT_RL: lo_q  <= mem_rdata_i;
        S_RET_SH:           sph_q <= mem_rdata_i[HIW-1:0];
        default: ;
      endcase
    end
  end

  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = done_q;
  assign ret_valid_o = rv_q;
  assign ret_addr_o  = ra_q;
  assign dsp_we_o    = dwe_q;
  assign dsp_o       = dsp_q;
  assign uf_fault_o  = uf_q;

  // R6
  uf_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_fault_o |-> (!ret_valid_o && !dsp_we_o));
  // R6
  uf_nomem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE && empty_i && !call_i) |-> !mem_req_o);
  // R4
  ret_dsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_o |-> (dsp_we_o && done_o));
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE && !call_i && !ret_i && !enter_i) |-> !mem_req_o);
endmodule

// File: rtl/ret_stack_unit.sv
module ret_stack_unit #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sup_i,
  input  logic          call_i,
  input  logic [AW-1:0] call_addr_i,
  input  logic          ret_i,
  input  logic [DW-1:0] ret_imm_i,
  input  logic          enter_i,
  input  logic [DW-1:0] enter_words_i,
  input  logic [AW-1:0] dsp_i,
  input  logic          rsp_wr_i,
  input  logic [AW-1:0] rsp_wdata_i,
  output logic [AW-1:0] rsp_rd_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          ret_valid_o,
  output logic [AW-1:0] ret_addr_o,
  output logic          dsp_we_o,
  output logic [AW-1:0] dsp_o,
  output logic          uf_fault_o,
  output logic          priv_fault_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  logic [AW-1:0] rsp, nxt;
  logic          empty, upd, busy;

  rsu_ptr #(.AW(AW)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .sup_i(sup_i),
    .wr_i(rsp_wr_i && !busy), .wdata_i(rsp_wdata_i),
    .upd_i(upd), .nxt_i(nxt), .rsp_o(rsp), .rd_o(rsp_rd_o),
    .empty_o(empty), .priv_fault_o(priv_fault_o)
  );

  rsu_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .call_i(call_i), .call_addr_i(call_addr_i),
    .ret_i(ret_i), .ret_imm_i(ret_imm_i),
    .enter_i(enter_i), .enter_words_i(enter_words_i),
    .dsp_i(dsp_i), .rsp_i(rsp), .empty_i(empty),
    .busy_o(busy), .done_o(done_o), .ret_valid_o(ret_valid_o),
    .ret_addr_o(ret_addr_o), .dsp_we_o(dsp_we_o), .dsp_o(dsp_o),
    .uf_fault_o(uf_fault_o), .upd_o(upd), .nxt_o(nxt),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  assign busy_o = busy;
endmodule

// File: tb/sim_ret_stack_unit.sv
`timescale 1ns/1ps
module sim_ret_stack_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_ni, sup_i, call_i, ret_i, enter_i, rsp_wr_i;
  logic [23:0] call_addr_i, dsp_i, rsp_wdata_i, rsp_rd_o, ret_addr_o, dsp_o, mem_addr_o;
  logic [15:0] ret_imm_i, enter_words_i, mem_wdata_o, mem_rdata_i;
  logic        busy_o, done_o, ret_valid_o, dsp_we_o, uf_fault_o, priv_fault_o;
  logic        mem_req_o, mem_we_o;

  ret_stack_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sup_i(sup_i),
    .call_i(call_i), .call_addr_i(call_addr_i),
    .ret_i(ret_i), .ret_imm_i(ret_imm_i),
    .enter_i(enter_i), .enter_words_i(enter_words_i), .dsp_i(dsp_i),
    .rsp_wr_i(rsp_wr_i), .rsp_wdata_i(rsp_wdata_i), .rsp_rd_o(rsp_rd_o),
    .busy_o(busy_o), .done_o(done_o), .ret_valid_o(ret_valid_o),
    .ret_addr_o(ret_addr_o), .dsp_we_o(dsp_we_o), .dsp_o(dsp_o),
    .uf_fault_o(uf_fault_o), .priv_fault_o(priv_fault_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  logic [15:0] mem [0:511];
  assign mem_rdata_i = mem[mem_addr_o[9:1]];
  always @(posedge clk) if (mem_req_o && mem_we_o) mem[mem_addr_o[9:1]] <= mem_wdata_o;

  localparam logic [23:0] BASE = 24'h000100;
  localparam int BI = 24'h000100 >> 1;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [23:0] cur_dsp, g_ra, g_dsp;
  logic        g_rv, g_dwe, g_uf, g_mem;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  // kind 0 call, 1 ret, 2 enter
  task automatic run_op(input int kind, input logic [23:0] a, input logic [15:0] v, output int lat);
    @(negedge clk);
    call_i = (kind == 0); ret_i = (kind == 1); enter_i = (kind == 2);
    call_addr_i = a; ret_imm_i = v; enter_words_i = v; dsp_i = cur_dsp;
    g_mem = mem_req_o;
    @(negedge clk);
    call_i = 0; ret_i = 0; enter_i = 0; lat = 1;
    while (!done_o && lat < 20) begin @(negedge clk); lat++; end
    g_rv = ret_valid_o; g_ra = ret_addr_o; g_dwe = dsp_we_o; g_dsp = dsp_o; g_uf = uf_fault_o;
    if (dsp_we_o) cur_dsp = dsp_o;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #500000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int lat;
    int sizes [8] = '{0, 1, 37, 128, 254, 255, 256, 1000};
    int imms  [3] = '{0, 4, 10};
    logic [23:0] a, orig, b;
    for (int k = 0; k < 512; k++) mem[k] = '0;
    rst_ni = 0; sup_i = 1; call_i = 0; ret_i = 0; enter_i = 0; rsp_wr_i = 0;
    call_addr_i = '0; ret_imm_i = '0; enter_words_i = '0; dsp_i = '0; rsp_wdata_i = '0;
    cur_dsp = 24'h400000;
    repeat (3) @(negedge clk);
    chk("R9 reset rsp", rsp_rd_o, 0);
    chk("R9 reset busy", busy_o, 0);
    chk("R9 reset done", done_o, 0);
    rst_ni = 1;
    @(negedge clk); rsp_wr_i = 1; rsp_wdata_i = BASE;
    @(negedge clk); rsp_wr_i = 0;
    chk("R7 supervisor load", rsp_rd_o, BASE);
    chk("R7 no priv fault", priv_fault_o, 0);

    // empty stack
    run_op(1, 0, 4, lat);
    chk("R6 ret uf", g_uf, 1);
    chk("R6 ret no target", g_rv, 0);
    chk("R6 ret no dsp", g_dwe, 0);
    chk("R6 ret no mem", g_mem, 0);
    chk("R6 ret rsp kept", rsp_rd_o, BASE);
    run_op(2, 0, 3, lat);
    chk("R6 enter uf", g_uf, 1);
    chk("R6 enter no dsp", g_dwe, 0);
    chk("R6 enter rsp kept", rsp_rd_o, BASE);

    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 3; j++) begin
        a = 24'hA00000 + 24'(i * 24'h1357) + 24'(j);
        orig = 24'h400000 + 24'((i * 3 + j) * 24'h100);
        cur_dsp = orig;
        run_op(0, a, 0, lat);
        chk("R10 call latency", lat, 2);
        chk("R1 call rsp", rsp_rd_o, BASE + 24'd4);
        chk("R1 low word", mem[BI], a[15:0]);
        chk("R1 high word", mem[BI+1], {8'h00, a[23:16]});
        run_op(2, 0, 16'(sizes[i]), lat);
        chk("R2 R3 enter dsp", g_dsp, orig - 24'(2 * sizes[i]));
        if (sizes[i] < 255) begin
          chk("R10 short enter latency", lat, 2);
          chk("R2 rsp kept", rsp_rd_o, BASE + 24'd4);
          chk("R2 size field", mem[BI+1], {8'(sizes[i]), a[23:16]});
        end else begin
          chk("R10 long enter latency", lat, 6);
          chk("R3 rsp", rsp_rd_o, BASE + 24'd8);
          chk("R3 sp low", mem[BI], orig[15:0]);
          chk("R3 sp high", mem[BI+1], {8'h00, orig[23:16]});
          chk("R3 ret low", mem[BI+2], a[15:0]);
          chk("R3 escape", mem[BI+3], {8'hFF, a[23:16]});
        end
        run_op(1, 0, 16'(imms[j]), lat);
        chk("R4 R5 ret valid", g_rv, 1);
        chk("R4 R5 ret addr", g_ra, a);
        chk("R4 R5 ret dsp", g_dsp, orig + 24'(imms[j]));
        chk("R4 R5 ret rsp", rsp_rd_o, BASE);
        chk(sizes[i] < 255 ? "R10 ret latency" : "R10 escape ret latency", lat, sizes[i] < 255 ? 2 : 4);
      end
    end

    // nested frames
    orig = 24'h500000; cur_dsp = orig;
    run_op(0, 24'h123456, 0, lat);
    run_op(2, 0, 16'd10, lat);
    b = cur_dsp;
    run_op(0, 24'hABCDEF, 0, lat);
    chk("R1 nested rsp", rsp_rd_o, BASE + 24'd8);
    run_op(2, 0, 16'd300, lat);
    chk("R3 nested rsp", rsp_rd_o, BASE + 24'd12);
    chk("R3 outer entry intact", mem[BI+1], {8'd10, 8'h12});
    run_op(1, 0, 16'd6, lat);
    chk("R5 nested addr", g_ra, 24'hABCDEF);
    chk("R5 nested dsp", g_dsp, b + 24'd6);
    chk("R5 nested rsp", rsp_rd_o, BASE + 24'd4);
    run_op(1, 0, 16'd2, lat);
    chk("R4 outer addr", g_ra, 24'h123456);
    chk("R4 outer dsp", g_dsp, b + 24'd6 + 24'd20 + 24'd2);
    chk("R4 outer rsp", rsp_rd_o, BASE);

    // privilege
    @(negedge clk); sup_i = 0;
    #1 chk("R8 user read zero", rsp_rd_o, 0);
    rsp_wr_i = 1; rsp_wdata_i = 24'h000040;
    @(negedge clk); rsp_wr_i = 0;
    chk("R7 priv fault", priv_fault_o, 1);
    sup_i = 1;
    #1 chk("R7 rsp unchanged", rsp_rd_o, BASE);
    @(negedge clk);
    chk("R7 fault one cycle", priv_fault_o, 0);
    run_op(1, 0, 0, lat);
    chk("R6 base kept after user write", g_uf, 1);

    finished = 1;
    summary();
    $finish;
  end
endmodule